// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the byte-wide host register window of a legacy Ethernet controller. A host reaches sixteen locations through a 4-bit offset. Offset 0 always holds the command byte. Bits [7:6] of the command byte pick a page, and that page decides which register the other fifteen offsets reach. A read and a write at the same offset can reach different registers. Writes take effect on the clock edge that samples the write strobe. Reads come straight from the selected register through combinational logic.

The block stores the controller's configuration:
- the receive ring limits and the boundary page,
- the transmit page and the transmit byte count,
- the remote DMA address and the remote DMA byte count,
- the data configuration byte,
- the interrupt status and interrupt mask,
- the station address, the current receive page and the multicast filter.

Neighbouring blocks read this configuration from dedicated output ports. They report their own events on a status strobe input. The block drives a level-sensitive interrupt line. It also issues a one-cycle transmit request together with the frame location and the frame length.

Top module: `nic_regfile`

## Requirements
- R1: After reset, the registers hold these values:
  - command byte 0x00;
  - interrupt status 0x80;
  - every other register 0x00;
  - `irq` and `tx_req` low.

  Offset 0 reads and writes the command byte whatever page is selected.
- R2: For offsets 1 to 15, the register index is {command[7:6], offset}. On pages 2 and 3, every offset reads 0x00 and writes change nothing.
- R3: Page 0 reads return:
  - offset 3: boundary page;
  - offset 4: transmit status;
  - offset 7: interrupt status;
  - offset 8: remote address low byte;
  - offset 9: remote address high byte.

  Every other page-0 offset reads 0x00.
- R4: Page 0 writes set:
  - offset 1: ring start page (`ring_start`);
  - offset 2: ring stop page (`ring_stop`);
  - offset 3: boundary page;
  - offset 4: transmit page (`tx_page`);
  - offsets 5 and 6: transmit count low and high bytes (`tx_count`);
  - offsets 8 and 9: remote address low and high bytes (`dma_addr`);
  - offsets 10 and 11: remote count low and high bytes (`dma_count`);
  - offset 14: data configuration (`data_cfg`);
  - offset 15: interrupt mask.

  Each new value appears on its output after the write edge.
- R5: Page 1 offsets are read/write:
  - offsets 1 to 6: station address bytes 0 to 5;
  - offset 7: current receive page;
  - offsets 8 to 15: multicast filter bytes 0 to 7.
- R6: A command write with bit 1 (start) set clears interrupt status bit 7.
- R7: A command write that meets all three conditions below sets interrupt status bit 6 (remote DMA complete):
  - bit 1 (start) is set;
  - bit 3 (remote read) or bit 4 (remote write) is set;
  - the remote byte count is zero.
- R8: A command write with bit 1 (start) and bit 2 (transmit) set has three effects:
  - `tx_req` is high for exactly the cycle after the write edge, while `tx_page` and `tx_count` hold the programmed values;
  - transmit status becomes 0x01;
  - interrupt status bit 1 is set.
- R9: A write to interrupt status clears each of bits [6:0] where the written byte has a 1. Bit 7 is never cleared by such a write.
- R10: `irq` is high exactly when (interrupt status AND interrupt mask) is nonzero.
- R11: A 1 on `ev_status[k]` sets interrupt status bit k (k = 0 to 6). When a set and a write-1 clear of the same bit happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ev_status | input | 7 | Event strobes that set interrupt status bits 6:0 |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| tx_page | output | 8 | Transmit start page (the frame begins at tx_page << 8) |
| tx_count | output | 16 | Transmit byte count |
| ring_start | output | 8 | Receive ring start page |
| ring_stop | output | 8 | Receive ring stop page |
| dma_addr | output | 16 | Remote DMA start address |
| dma_count | output | 16 | Remote DMA byte count |
| data_cfg | output | 8 | Data configuration byte |

## Verification
The hardest case to reach is a collision inside the interrupt status register. An event strobe can set a bit in the same cycle that a host write clears it. The bench forces this by driving `ev_status` during the write strobe to offset 7, and then reads the status back.

The zero-count remote DMA case is the second hard case, because it depends on the remote count already held in the block. The bench first issues the start command with the remote count left at zero. It then reissues the command after loading a nonzero count, so both outcomes are observed.

Page aliasing is reached by switching the command page between writes. Each register is then read back from the page on which it lives.

// File: rtl/nic_regfile_pkg.sv
package nic_regfile_pkg;
  localparam int DW     = 8;
  localparam int OFS_W  = 4;
  localparam int PAGE_W = 2;
  localparam int IDX_W  = OFS_W + PAGE_W;

  // command byte bit positions
  localparam int CB_START = 1;
  localparam int CB_XMIT  = 2;
  localparam int CB_RRD   = 3;
  localparam int CB_RWR   = 4;

  // interrupt status bit positions
  localparam int IS_TXOK  = 1;
  localparam int IS_DMAOK = 6;

  // register indices {page, offset}
  localparam logic [IDX_W-1:0] IX_RING_LO = 6'h01;
  localparam logic [IDX_W-1:0] IX_RING_HI = 6'h02;
  localparam logic [IDX_W-1:0] IX_BOUND   = 6'h03;
  localparam logic [IDX_W-1:0] IX_XPAGE   = 6'h04; // write: tx page, read: tx status
  localparam logic [IDX_W-1:0] IX_XLEN_L  = 6'h05;
  localparam logic [IDX_W-1:0] IX_XLEN_H  = 6'h06;
  localparam logic [IDX_W-1:0] IX_INTST   = 6'h07;
  localparam logic [IDX_W-1:0] IX_RADR_L  = 6'h08;
  localparam logic [IDX_W-1:0] IX_RADR_H  = 6'h09;
  localparam logic [IDX_W-1:0] IX_RLEN_L  = 6'h0A;
  localparam logic [IDX_W-1:0] IX_RLEN_H  = 6'h0B;
  localparam logic [IDX_W-1:0] IX_DCONF   = 6'h0E;
  localparam logic [IDX_W-1:0] IX_INTMSK  = 6'h0F;
  localparam logic [IDX_W-1:0] IX_STA_FIRST = 6'h11;
  localparam logic [IDX_W-1:0] IX_STA_LAST  = 6'h16;
  localparam logic [IDX_W-1:0] IX_RXPAGE  = 6'h17;
  localparam logic [2:0]       IX_MC_HI3  = 3'b011; // 0x18..0x1F
endpackage

// File: rtl/nic_page_decode.sv
module nic_page_decode
  import nic_regfile_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              we,
  output logic [IDX_W-1:0]  idx,
  output logic              cmd_sel,
  output logic              wr_cmd,
  output logic              wr_reg
);
  assign cmd_sel = (ofs == '0);
  assign idx     = {page, ofs};
  assign wr_cmd  = we & cmd_sel;
  assign wr_reg  = we & ~cmd_sel;
endmodule

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank #(
  parameter int BYTES = 6,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(BYTES)-1:0] widx,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(BYTES)-1:0] ridx,
  output logic [DW-1:0]            rdata
);
  localparam int IW = $clog2(BYTES);

  logic [DW-1:0] mem_q [BYTES];
  logic [DW-1:0] mem_d [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    always_comb begin
      mem_d[g] = mem_q[g];
      if (we && (widx == IW'(g))) mem_d[g] = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= mem_d[g];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < BYTES; i++)
      if (ridx == IW'(i)) rdata = mem_q[i];
  end
endmodule

// File: rtl/nic_isr_ctrl.sv
module nic_isr_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_cmd,
  input  logic         clr_en,
  input  logic [W-2:0] clr_mask,
  input  logic [W-2:0] set_vec,
  input  logic         imr_we,
  input  logic [W-1:0] imr_wdata,
  output logic [W-1:0] isr_q,
  output logic         irq
);
  logic [W-1:0] isr_d, imr_q, imr_d;

  always_comb begin
    isr_d = isr_q;
    if (start_cmd) isr_d[W-1] = 1'b0;
    if (clr_en)    isr_d[W-2:0] = isr_d[W-2:0] & ~clr_mask;
    isr_d[W-2:0] = isr_d[W-2:0] | set_vec;
    imr_d = imr_we ? imr_wdata : imr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= {1'b1, {(W-1){1'b0}}};
      imr_q <= '0;
    end else begin
      isr_q <= isr_d;
      imr_q <= imr_d;
    end
  end

  assign irq = |(isr_q & imr_q);

  // R9: the reset-complete bit can only be set by reset
  p_rst_bit_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(isr_q[W-1]));

  // R9: a write-1 clear with no concurrent set leaves the bit low
  p_clear_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mask[0] && !set_vec[0]) |=> !isr_q[0]);

  // R11: a set strobe always lands, even against a clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> isr_q[0]);

  // R10: with an all-zero mask the line stays low
  p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == '0) |-> !irq);
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_regfile_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [DW-2:0]   ev_status,
  output logic            irq,
  output logic            tx_req,
  output logic [DW-1:0]   tx_page,
  output logic [2*DW-1:0] tx_count,
  output logic [DW-1:0]   ring_start,
  output logic [DW-1:0]   ring_stop,
  output logic [2*DW-1:0] dma_addr,
  output logic [2*DW-1:0] dma_count,
  output logic [DW-1:0]   data_cfg
);
  localparam int STA_BYTES = 6;
  localparam int MC_BYTES  = 8;
  localparam int STA_IW    = $clog2(STA_BYTES);
  localparam int MC_IW     = $clog2(MC_BYTES);

  logic [DW-1:0]   cmd_q, cmd_d, rlo_q, rlo_d, rhi_q, rhi_d, bnd_q, bnd_d;
  logic [DW-1:0]   xpg_q, xpg_d, tst_q, tst_d, dcf_q, dcf_d, rxp_q, rxp_d;
  logic [2*DW-1:0] xln_q, xln_d, rad_q, rad_d, rln_q, rln_d;
  logic            txr_q, txr_d;

  logic [IDX_W-1:0] idx;
  logic             cmd_sel, wr_cmd, wr_reg;
  logic             start_cmd, tx_fire, dma_zero;
  logic [DW-1:0]    isr_q, sta_rd, mc_rd;
  logic [DW-2:0]    set_vec;
  logic             sta_we, mc_we;
  logic [STA_IW-1:0] sta_idx;
  logic [MC_IW-1:0]  mc_idx;

  nic_page_decode u_dec (
    .page(cmd_q[DW-1 -: PAGE_W]), .ofs(reg_addr), .we(reg_we),
    .idx(idx), .cmd_sel(cmd_sel), .wr_cmd(wr_cmd), .wr_reg(wr_reg)
  );

  assign start_cmd = wr_cmd & reg_wdata[CB_START];
  assign tx_fire   = start_cmd & reg_wdata[CB_XMIT];
  assign dma_zero  = start_cmd & (reg_wdata[CB_RRD] | reg_wdata[CB_RWR]) & (rln_q == '0);

  always_comb begin
    set_vec = ev_status;
    set_vec[IS_TXOK]  = ev_status[IS_TXOK] | tx_fire;
    set_vec[IS_DMAOK] = ev_status[IS_DMAOK] | dma_zero;
  end

  nic_isr_ctrl #(.W(DW)) u_isr (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd),
    .clr_en(wr_reg && (idx == IX_INTST)), .clr_mask(reg_wdata[DW-2:0]),
    .set_vec(set_vec), .imr_we(wr_reg && (idx == IX_INTMSK)),
    .imr_wdata(reg_wdata), .isr_q(isr_q), .irq(irq)
  );

  assign sta_we  = wr_reg && (idx >= IX_STA_FIRST) && (idx <= IX_STA_LAST);
  assign mc_we   = wr_reg && (idx[IDX_W-1 -: 3] == IX_MC_HI3);
  assign sta_idx = STA_IW'(reg_addr - OFS_W'(1));
  assign mc_idx  = reg_addr[MC_IW-1:0];

  nic_cfg_bank #(.BYTES(STA_BYTES), .DW(DW)) u_sta (
    .clk(clk), .rst_n(rst_n), .we(sta_we), .widx(sta_idx),
    .wdata(reg_wdata), .ridx(sta_idx), .rdata(sta_rd)
  );

  nic_cfg_bank #(.BYTES(MC_BYTES), .DW(DW)) u_mc (
    .clk(clk), .rst_n(rst_n), .we(mc_we), .widx(mc_idx),
    .wdata(reg_wdata), .ridx(mc_idx), .rdata(mc_rd)
  );

  always_comb begin
    cmd_d = cmd_q; rlo_d = rlo_q; rhi_d = rhi_q; bnd_d = bnd_q;
    xpg_d = xpg_q; tst_d = tst_q; dcf_d = dcf_q; rxp_d = rxp_q;
    xln_d = xln_q; rad_d = rad_q; rln_d = rln_q;
    txr_d = tx_fire;
    if (wr_cmd) cmd_d = reg_wdata;
    if (tx_fire) tst_d = DW'(1);
    if (wr_reg) begin
      case (idx)
        IX_RING_LO: rlo_d = reg_wdata;
        IX_RING_HI: rhi_d = reg_wdata;
        IX_BOUND:   bnd_d = reg_wdata;
        IX_XPAGE:   xpg_d = reg_wdata;
        IX_XLEN_L:  xln_d[DW-1:0]    = reg_wdata;
        IX_XLEN_H:  xln_d[2*DW-1:DW] = reg_wdata;
        IX_RADR_L:  rad_d[DW-1:0]    = reg_wdata;
        IX_RADR_H:  rad_d[2*DW-1:DW] = reg_wdata;
        IX_RLEN_L:  rln_d[DW-1:0]    = reg_wdata;
        IX_RLEN_H:  rln_d[2*DW-1:DW] = reg_wdata;
        IX_DCONF:   dcf_d = reg_wdata;
        IX_RXPAGE:  rxp_d = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; rlo_q <= '0; rhi_q <= '0; bnd_q <= '0;
      xpg_q <= '0; tst_q <= '0; dcf_q <= '0; rxp_q <= '0;
      xln_q <= '0; rad_q <= '0; rln_q <= '0; txr_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d; rlo_q <= rlo_d; rhi_q <= rhi_d; bnd_q <= bnd_d;
      xpg_q <= xpg_d; tst_q <= tst_d; dcf_q <= dcf_d; rxp_q <= rxp_d;
      xln_q <= xln_d; rad_q <= rad_d; rln_q <= rln_d; txr_q <= txr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (cmd_sel) reg_rdata = cmd_q;
    else if (idx >= IX_STA_FIRST && idx <= IX_STA_LAST) reg_rdata = sta_rd;
    else if (idx[IDX_W-1 -: 3] == IX_MC_HI3) reg_rdata = mc_rd;
    else begin
      case (idx)
        IX_BOUND:  reg_rdata = bnd_q;
        IX_XPAGE:  reg_rdata = tst_q;
        IX_INTST:  reg_rdata = isr_q;
        IX_RADR_L: reg_rdata = rad_q[DW-1:0];
        IX_RADR_H: reg_rdata = rad_q[2*DW-1:DW];
        IX_RXPAGE: reg_rdata = rxp_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign tx_req     = txr_q;
  assign tx_page    = xpg_q;
  assign tx_count   = xln_q;
  assign ring_start = rlo_q;
  assign ring_stop  = rhi_q;
  assign dma_addr   = rad_q;
  assign dma_count  = rln_q;
  assign data_cfg   = dcf_q;

  // R6: start clears the reset-complete status bit
  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[CB_START]) |=> !isr_q[DW-1]);

  // R7: zero-length remote transfer completes at once
  p_zero_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[CB_START] && (reg_wdata[CB_RRD] || reg_wdata[CB_RWR])
     && (dma_count == '0)) |=> isr_q[IS_DMAOK]);

  // R8: request only follows a start+transmit command write
  p_tx_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(reg_we && (reg_addr == '0) && reg_wdata[CB_START] && reg_wdata[CB_XMIT]));

  // R8: transmit completion reported
  p_tx_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> isr_q[IS_TXOK]);
endmodule

// File: tb/nic_regfile_test.sv
module nic_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [6:0]  ev_status;
  logic        irq, tx_req;
  logic [7:0]  tx_page, ring_start, ring_stop, data_cfg;
  logic [15:0] tx_count, dma_addr, dma_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nic_regfile uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_status(ev_status),
    .irq(irq), .tx_req(tx_req), .tx_page(tx_page), .tx_count(tx_count),
    .ring_start(ring_start), .ring_stop(ring_stop), .dma_addr(dma_addr),
    .dma_count(dma_count), .data_cfg(data_cfg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [6:0] ev = '0);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; ev_status = ev;
    @(negedge clk);
    reg_we = 1'b0; ev_status = '0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1 cmd", 4'h0, 8'h00);
    rd_chk("R1 isr", 4'h7, 8'h80);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 tx_req", {15'd0, tx_req}, 16'd0);
    check("R1 tx_count", tx_count, 16'h0000);
    wr(4'h7, 8'hFF);
    rd_chk("R9 bit7 kept", 4'h7, 8'h80);
  endtask

  task automatic t_page1;
    wr(4'h0, 8'h40);
    rd_chk("R1 cmd page1", 4'h0, 8'h40);
    for (int i = 1; i < 16; i++) wr(4'(i), 8'(8'hA0 + i));
    for (int i = 1; i < 16; i++) rd_chk("R5 page1", 4'(i), 8'(8'hA0 + i));
    wr(4'h0, 8'h00);
    rd_chk("R2 page0 alias", 4'h7, 8'h80);
  endtask

  task automatic t_page0;
    wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'h3, 8'h4C);
    wr(4'h8, 8'h34); wr(4'h9, 8'h12); wr(4'hE, 8'h49);
    check("R4 ring_start", {8'h00, ring_start}, 16'h0046);
    check("R4 ring_stop", {8'h00, ring_stop}, 16'h0080);
    check("R4 dma_addr", dma_addr, 16'h1234);
    check("R4 data_cfg", {8'h00, data_cfg}, 16'h0049);
    rd_chk("R3 boundary", 4'h3, 8'h4C);
    rd_chk("R3 radr lo", 4'h8, 8'h34);
    rd_chk("R3 radr hi", 4'h9, 8'h12);
    rd_chk("R3 write-only", 4'h1, 8'h00);
  endtask

  task automatic t_page23;
    wr(4'h0, 8'h80);
    wr(4'h3, 8'hAA);
    rd_chk("R2 page2 read", 4'h3, 8'h00);
    wr(4'h0, 8'hC0);
    rd_chk("R2 page3 read", 4'h7, 8'h00);
    wr(4'h0, 8'h00);
    rd_chk("R2 page2 write ignored", 4'h3, 8'h4C);
  endtask

  task automatic t_start;
    wr(4'h0, 8'h22);
    rd_chk("R6 start clears bit7", 4'h7, 8'h00);
  endtask

  task automatic t_zero_dma;
    wr(4'h0, 8'h0A);
    rd_chk("R7 zero count", 4'h7, 8'h40);
    wr(4'h7, 8'h40);
    rd_chk("R9 clear bit6", 4'h7, 8'h00);
    wr(4'hA, 8'h05);
    check("R4 dma_count", dma_count, 16'h0005);
    wr(4'h0, 8'h0A);
    rd_chk("R7 nonzero count", 4'h7, 8'h00);
  endtask

  task automatic t_tx;
    wr(4'h4, 8'h40); wr(4'h5, 8'h3C); wr(4'h6, 8'h05);
    wr(4'h0, 8'h26);
    check("R8 tx_req high", {15'd0, tx_req}, 16'd1);
    check("R8 tx_page", {8'h00, tx_page}, 16'h0040);
    check("R8 tx_count", tx_count, 16'h053C);
    rd_chk("R8 tx status", 4'h4, 8'h01);
    rd_chk("R8 isr bit1", 4'h7, 8'h02);
    @(negedge clk);
    check("R8 tx_req pulse", {15'd0, tx_req}, 16'd0);
  endtask

  task automatic t_irq;
    wr(4'hF, 8'h02);
    check("R10 irq on", {15'd0, irq}, 16'd1);
    wr(4'hF, 8'h01);
    check("R10 irq masked", {15'd0, irq}, 16'd0);
    wr(4'h7, 8'h02);
    rd_chk("R9 clear bit1", 4'h7, 8'h00);
  endtask

  task automatic t_events;
    @(negedge clk); ev_status = 7'h04;
    @(negedge clk); ev_status = '0;
    rd_chk("R11 event set", 4'h7, 8'h04);
    check("R10 irq off", {15'd0, irq}, 16'd0);
    wr(4'h7, 8'h01, 7'h01);
    rd_chk("R11 set beats clear", 4'h7, 8'h05);
    check("R10 irq event", {15'd0, irq}, 16'd1);
    wr(4'h7, 8'h05);
    rd_chk("R9 clear all", 4'h7, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; ev_status = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_page1;
    t_page0;
    t_page23;
    t_start;
    t_zero_dma;
    t_tx;
    t_irq;
    t_events;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule